// File: doc/BRIEF.md
# APB UART Register Block

This block is the register side of a simple UART, seen from an APB bus. A byte-stream port (valid plus eight data bits) stands in for the serial receiver. A byte-stream output with a one-cycle strobe stands in for the transmitter. Received bytes go into a receive FIFO whose depth is a parameter. Software drains the FIFO through the data register, sends bytes through the same register, and watches progress through a status word. A single interrupt line pulses for one clock on each accepted byte or sent byte, when the matching interrupt enable is set.

Serial framing, baud generation, parity, break and flow control are not implemented. Their control bits are only stored and read back. The bus side has no wait states and never signals an error.

Top module: `apbu_top`

## Requirements
- R1: After reset, the status word reads 0x6 (bit 1 and bit 2 set), the control word reads 0, and `irq` and `tx_valid` are low.
- R2: A write to offset 0x08 stores all 32 bits. A read of 0x08 returns them unchanged.
- R3: A byte on `rx_valid`/`rx_data` enters the receive FIFO only while control bit 0 is set, and accepting it sets status bit 0. With bit 0 clear, the byte is dropped and the FIFO does not change.
- R4: When a byte is accepted and control bit 2 is set, `irq` is high for exactly the one clock after the accepting edge.
- R5: A write to the data register (offset 0x00 or 0x03) with control bit 1 set drives `tx_valid` high for one clock, with `tx_data` equal to the low 8 bits written. With bit 1 clear, the write is dropped.
- R6: A transmitted write with control bit 3 set pulses `irq` for one clock, in the same cycle as `tx_valid`.
- R7: A read of the data register returns the oldest byte, zero-extended, and pops it once. Status bit 0 clears when the FIFO becomes empty. A read of an empty FIFO returns 0.
- R8: Offset 0x03 reads and writes the data register exactly as offset 0x00 does.
- R9: Writes to the status word (0x04) are ignored. The scaler (0x0C), FIFO debug (0x10) and every unmapped offset read as 0 and ignore writes.
- R10: Status bit 8 is set while the FIFO holds at least half its depth. Status bit 10 is set while the FIFO is full.
- R11: A byte arriving while the FIFO is full is dropped and sets status bit 4. A read of the status word clears bit 4, and that read still returns bit 4 set.
- R12: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte strobe, one clock |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench fills the FIFO to exactly its depth and then sends one more byte. A design with an off-by-one on the full flag would either store the extra byte or drop the last legal one, and the order of the drained bytes exposes both faults. It reads the status word twice in a row after an overrun, which catches an overrun bit that never clears or one that clears before the first read returns it. It also reads and writes the data register at offset 3, reads an empty FIFO, and sends bytes with receive or transmit disabled. A broken gate there would show up as a stray `tx_valid`, a stray interrupt or a phantom data-ready bit.

// File: rtl/apbu_pkg.sv
`timescale 1ns/1ps
package apbu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DATA_B = 8'h03;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;

  // status bit positions
  localparam int unsigned ST_RDY   = 0;
  localparam int unsigned ST_SHE   = 1;
  localparam int unsigned ST_TQE   = 2;
  localparam int unsigned ST_OVR   = 4;
  localparam int unsigned ST_RHALF = 8;
  localparam int unsigned ST_RFULL = 10;

  // control bit positions
  localparam int unsigned CT_RXEN = 0;
  localparam int unsigned CT_TXEN = 1;
  localparam int unsigned CT_RXIE = 2;
  localparam int unsigned CT_TXIE = 3;

  typedef enum logic [1:0] {SEL_ZERO, SEL_DATA, SEL_STAT, SEL_CTRL} reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    case (off)
      OFF_DATA, OFF_DATA_B: return SEL_DATA;
      OFF_STAT:             return SEL_STAT;
      OFF_CTRL:             return SEL_CTRL;
      default:              return SEL_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/apbu_rx_fifo.sv
`timescale 1ns/1ps
module apbu_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstn,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = push_i ? bump(wptr_q) : wptr_q;
    rptr_d = pop_i  ? bump(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    else if (!push_i && pop_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstn)
    cnt_q <= CW'(DEPTH));
  // R11
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstn)
    push_i |-> (cnt_q != CW'(DEPTH)));
  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstn)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/apbu_status.sv
`timescale 1ns/1ps
module apbu_status
  import apbu_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic [CW-1:0]     count_i,
  input  logic              ovr_set_i,
  input  logic              stat_rd_i,
  output logic [WORD_W-1:0] status_o
);
  logic ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set_i) ovr_d = 1'b1;
    else if (stat_rd_i) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) ovr_q <= 1'b0;
    else       ovr_q <= ovr_d;
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_RDY]   = (count_i != '0);
    status_o[ST_SHE]   = 1'b1;
    status_o[ST_TQE]   = 1'b1;
    status_o[ST_OVR]   = ovr_q;
    status_o[ST_RHALF] = (count_i >= CW'(DEPTH / 2));
    status_o[ST_RFULL] = (count_i == CW'(DEPTH));
  end

  // R11
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstn)
    (stat_rd_i && !ovr_set_i) |=> !status_o[ST_OVR]);
  // R11
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstn)
    ovr_set_i |=> status_o[ST_OVR]);
endmodule

// File: rtl/apbu_top.sv
`timescale 1ns/1ps
module apbu_top
  import apbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  reg_sel_e            sel;
  logic                wr_acc, rd_acc;
  logic [WORD_W-1:0]   ctrl_q, ctrl_d;
  logic                txv_q, txv_d, irq_q, irq_d;
  logic [BYTE_W-1:0]   txd_q, txd_d;
  logic                rx_take, rx_drop, fifo_pop, fifo_full, fifo_empty;
  logic [BYTE_W-1:0]   fifo_rd;
  logic [CW-1:0]       fifo_cnt;
  logic [WORD_W-1:0]   status;
  logic                tx_fire;

  assign sel     = decode_off(paddr[7:0]);
  assign wr_acc  = psel && penable && pwrite;
  assign rd_acc  = psel && penable && !pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign fifo_full  = (fifo_cnt == CW'(DEPTH));
  assign fifo_empty = (fifo_cnt == '0);
  assign rx_take    = rx_valid && ctrl_q[CT_RXEN] && !fifo_full;
  assign rx_drop    = rx_valid && ctrl_q[CT_RXEN] && fifo_full;
  assign fifo_pop   = rd_acc && (sel == SEL_DATA) && !fifo_empty;
  assign tx_fire    = wr_acc && (sel == SEL_DATA) && ctrl_q[CT_TXEN];

  apbu_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(pclk), .rstn(presetn),
    .push_i(rx_take), .wdata_i(rx_data),
    .pop_i(fifo_pop), .rdata_o(fifo_rd), .count_o(fifo_cnt)
  );

  apbu_status #(.DEPTH(DEPTH)) u_status (
    .clk(pclk), .rstn(presetn),
    .count_i(fifo_cnt), .ovr_set_i(rx_drop),
    .stat_rd_i(rd_acc && (sel == SEL_STAT)),
    .status_o(status)
  );

  always_comb begin
    ctrl_d = (wr_acc && sel == SEL_CTRL) ? pwdata : ctrl_q;
    txv_d  = tx_fire;
    txd_d  = tx_fire ? pwdata[BYTE_W-1:0] : txd_q;
    irq_d  = (rx_take && ctrl_q[CT_RXIE]) || (tx_fire && ctrl_q[CT_TXIE]);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q <= '0;
      txv_q  <= 1'b0;
      txd_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      txv_q  <= txv_d;
      txd_q  <= txd_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: prdata = fifo_empty ? '0 : WORD_W'(fifo_rd);
      SEL_STAT: prdata = status;
      SEL_CTRL: prdata = ctrl_q;
      default:  prdata = '0;
    endcase
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;
  assign irq      = irq_q;

  // R5
  tx_gate_chk: assert property (@(posedge pclk) disable iff (!presetn)
    tx_valid |-> $past(ctrl_q[CT_TXEN]));
  // R3
  rx_off_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (!ctrl_q[CT_RXEN] && !fifo_pop) |=> $stable(fifo_cnt));
  // R4
  irq_cause_chk: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> $past(ctrl_q[CT_RXIE] || ctrl_q[CT_TXIE]));
  // R12
  bus_ok_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);
endmodule

// File: tb/tb_apbu_top.sv
`timescale 1ns/1ps
module tb_apbu_top;
  localparam int DEPTH = 16;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int checks = 0, failures = 0;
  logic        l_txv, l_irq;
  logic [7:0]  l_txd;

  always #10 pclk = ~pclk;

  apbu_top #(.ADDR_W(8), .DEPTH(DEPTH)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    l_txv = tx_valid; l_txd = tx_data; l_irq = irq;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    check("R12 bus", {30'b0, pready, pslverr}, 32'h2);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b, output logic irq_seen);
    @(negedge pclk); rx_valid = 1; rx_data = b;
    @(negedge pclk); rx_valid = 0;
    irq_seen = irq;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx_valid", {31'b0, tx_valid}, 0);
    apb_read(8'h04, v); check("R1 status", v, 32'h6);
    apb_read(8'h08, v); check("R1 control", v, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    apb_write(8'h08, 32'hA5A5_1FF0); apb_read(8'h08, v);
    check("R2 control readback", v, 32'hA5A5_1FF0);
    apb_write(8'h08, 32'h8000_0000); apb_read(8'h08, v);
    check("R2 control bit31", v, 32'h8000_0000);
  endtask

  task automatic t_rx_disabled();
    logic [31:0] v; logic s;
    apb_write(8'h08, 32'h4);          // irq enabled, rx off
    rx_byte(8'h11, s);
    check("R3 no irq when rx off", {31'b0, s}, 0);
    apb_read(8'h04, v); check("R3 no data ready when rx off", v, 32'h6);
    apb_read(8'h00, v); check("R3 empty after drop", v, 0);
  endtask

  task automatic t_rx_irq();
    logic [31:0] v; logic s;
    apb_write(8'h08, 32'h5);          // rx on, rx irq on
    rx_byte(8'h3C, s);
    check("R4 rx irq pulse", {31'b0, s}, 1);
    @(negedge pclk); check("R4 irq one cycle", {31'b0, irq}, 0);
    apb_read(8'h04, v); check("R3 data ready", v, 32'h7);
    apb_read(8'h03, v); check("R8 read at offset 3", v, 32'h3C);
    apb_read(8'h04, v); check("R7 data ready clears", v, 32'h6);
    apb_read(8'h00, v); check("R7 empty read zero", v, 0);
    apb_write(8'h08, 32'h1);
    rx_byte(8'h44, s);
    check("R4 no irq when bit2 clear", {31'b0, s}, 0);
    apb_read(8'h00, v); check("R7 pop byte", v, 32'h44);
  endtask

  task automatic t_tx();
    apb_write(8'h08, 32'h0);
    apb_write(8'h00, 32'h1234_5678);
    check("R5 tx dropped when off", {31'b0, l_txv}, 0);
    apb_write(8'h08, 32'h2);
    apb_write(8'h00, 32'hFFFF_FF9A);
    check("R5 tx_valid", {31'b0, l_txv}, 1);
    check("R5 tx_data", {24'b0, l_txd}, 32'h9A);
    check("R6 no irq when bit3 clear", {31'b0, l_irq}, 0);
    @(negedge pclk); check("R5 tx one cycle", {31'b0, tx_valid}, 0);
    apb_write(8'h08, 32'hA);
    apb_write(8'h03, 32'h0000_0021);
    check("R8 tx at offset 3", {24'b0, l_txd}, 32'h21);
    check("R6 tx irq", {31'b0, l_irq}, 1);
    check("R5 tx_valid offset 3", {31'b0, l_txv}, 1);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    apb_write(8'h04, 32'hFFFF_FFFF); apb_read(8'h04, v);
    check("R9 status write ignored", v, 32'h6);
    apb_write(8'h0C, 32'hFFFF); apb_read(8'h0C, v); check("R9 scaler zero", v, 0);
    apb_write(8'h10, 32'hFFFF); apb_read(8'h10, v); check("R9 debug zero", v, 0);
    apb_write(8'h14, 32'hFFFF); apb_read(8'h14, v); check("R9 unmapped zero", v, 0);
    apb_read(8'h08, v); check("R9 control untouched", v, 32'hA);
  endtask

  task automatic t_fill();
    logic [31:0] v; logic s;
    apb_write(8'h08, 32'h1);
    for (int i = 0; i < DEPTH / 2 - 1; i++) rx_byte(8'(8'h80 + i), s);
    apb_read(8'h04, v); check("R10 below half", v, 32'h7);
    rx_byte(8'(8'h80 + DEPTH / 2 - 1), s);
    apb_read(8'h04, v); check("R10 half", v, 32'h107);
    for (int i = DEPTH / 2; i < DEPTH - 1; i++) rx_byte(8'(8'h80 + i), s);
    apb_read(8'h04, v); check("R10 not yet full", v, 32'h107);
    rx_byte(8'(8'h80 + DEPTH - 1), s);
    apb_read(8'h04, v); check("R10 full", v, 32'h507);
    rx_byte(8'hEE, s);
    apb_read(8'h04, v); check("R11 overrun set", v, 32'h517);
    apb_read(8'h04, v); check("R11 overrun cleared by read", v, 32'h507);
    for (int i = 0; i < DEPTH; i++) begin
      apb_read(8'h00, v); check("R7 drain order", v, 32'(8'h80 + i));
    end
    apb_read(8'h04, v); check("R7 empty after drain", v, 32'h6);
    apb_read(8'h00, v); check("R11 overflow byte dropped", v, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    t_reset();
    t_ctrl();
    t_rx_disabled();
    t_rx_irq();
    t_tx();
    t_ignored();
    t_fill();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule